// File: doc/BRIEF.md
# Status Register and Write-Permission Guard

This block owns the status byte of a serial non-volatile memory and decides whether each write may go ahead. It keeps a write-enable latch, a two-bit protection level that fences off an upper part of the array, and a bit that arms the external write-protect pin. It also shows whether the memory is busy. The command decoder sends one-cycle strobes that set or clear the latch, requests to rewrite the status byte, and address queries for array programming. The program sequencer reports its busy state and signals when a write has completed.

A status write passes through a short state machine. ST_IDLE accepts or refuses the request (transition IDLE_TO_PEND on acceptance). ST_PEND holds the captured byte for one cycle and gives the pin a last chance to veto it (PEND_ABORT back to ST_IDLE, or PEND_COMMIT to ST_CYCLE, at which the new bits are loaded). ST_CYCLE is a self-timed busy period of `SR_CYC_LEN` cycles. Its last cycle takes CYCLE_DONE back to ST_IDLE and clears the write-enable latch. While this period runs, the busy flag is shared with the program sequencer's busy signal.

Top module: `statreg_guard`

## Requirements
- R1: `status_o` bit 7 is the pin-arm bit, bits 6..4 always read 0, bits 3..2 are the protection level, bit 1 is the write-enable bit and bit 0 is the busy bit. After reset the byte is 8'h00 and every grant and deny output is 0.
- R2: `wen_set_i` sets the write-enable latch unless the block is busy. `wen_clr_i` clears it whatever the pin level. If both are high in the same cycle, the latch is cleared.
- R3: A status write request is accepted in ST_IDLE only when the latch is set, nothing is busy, and either `wp_n_i` is high or bit 7 is 0. Otherwise `sr_wr_deny_o` pulses for one cycle, one cycle after the request, and the byte does not change.
- R4: An accepted request pulses `sr_wr_grant_o` two cycles after the request. In that same cycle, bits 7, 3 and 2 take the request's data bits 7, 3 and 2. The other data bits are ignored.
- R5: While bit 7 is 1 and `wp_n_i` is low, no status write changes the byte, so bit 7 cannot be cleared.
- R6: If, in the ST_PEND cycle, `wp_n_i` is low while bit 7 is 1, or the latch has been lost, the write is abandoned. `sr_wr_deny_o` pulses, the byte is unchanged, the latch keeps its value and no busy period follows.
- R7: A committed status write reads busy for exactly `SR_CYC_LEN` cycles starting in the grant cycle. Bits 1 and 0 both read 1 throughout. The latch is clear when the busy period ends.
- R8: While `prog_busy_i` is high, bits 1 and 0 read 1. `wr_done_i` clears the latch.
- R9: A query on `chk_valid_i` yields, one cycle later, `arr_grant_o` when the latch is set, the block is not busy and the address lies outside the protected region. Otherwise it yields `arr_deny_o`.
- R10: The protected region is set by the protection level. Level 00 protects nothing. Level 01 protects addresses whose two top bits are 11 (30000h–3FFFFh at 18 bits). Level 10 protects addresses whose top bit is 1. Level 11 protects the whole array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wen_set_i | input | 1 | Strobe that sets the write-enable latch |
| wen_clr_i | input | 1 | Strobe that clears the write-enable latch |
| sr_wr_req_i | input | 1 | Status write request strobe |
| sr_wr_data_i | input | 8 | Byte offered with the status write |
| chk_valid_i | input | 1 | Array write permission query strobe |
| chk_addr_i | input | ADDR_W | Array address being queried |
| prog_busy_i | input | 1 | Program sequencer busy |
| wr_done_i | input | 1 | Program sequencer write-complete strobe |
| wp_n_i | input | 1 | Write-protect pin, low protects |
| status_o | output | 8 | Status byte for reads |
| sr_wr_grant_o | output | 1 | Status write committed |
| sr_wr_deny_o | output | 1 | Status write refused or abandoned |
| arr_grant_o | output | 1 | Array write allowed |
| arr_deny_o | output | 1 | Array write refused |

## Verification
The assertions assume that the decoder raises at most one status write request at a time and holds each strobe for a single cycle. They also assume `wr_done_i` arrives only as the program sequencer ends its own busy period. The stimulus drives every strobe for exactly one clock, starting at a falling edge. It waits for the busy bit to drop before issuing a new status write, and it moves the pin only between commands, except in the directed case that drops it during ST_PEND on purpose.

// File: rtl/swp_pkg.sv
package swp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_CYCLE = 2'd2
    } sr_state_e;

    localparam int SB_ARM  = 7;
    localparam int SB_LVL1 = 3;
    localparam int SB_LVL0 = 2;
    localparam int SB_WEL  = 1;
    localparam int SB_BUSY = 0;
endpackage

// File: rtl/swp_region.sv
module swp_region #(
    parameter int ADDR_W = 18
) (
    input  logic [1:0]        level_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    logic [1:0] top;
    assign top = addr_i[ADDR_W-1 -: 2];

    always_comb begin
        unique case (level_i)
            2'b00:   hit_o = 1'b0;
            2'b01:   hit_o = (top == 2'b11);
            2'b10:   hit_o = top[1];
            default: hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/swp_wel.sv
module swp_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic busy_i,
    output logic wel_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wel_o <= 1'b0;
        else if (clr_i)
            wel_o <= 1'b0;
        else if (set_i && !busy_i)
            wel_o <= 1'b1;
    end
endmodule

// File: rtl/swp_sr_fsm.sv
module swp_sr_fsm
    import swp_pkg::*;
#(
    parameter int CYC_LEN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic [7:0] data_i,
    input  logic       wel_i,
    input  logic       arm_i,
    input  logic       wp_n_i,
    input  logic       ext_busy_i,
    output logic       commit_o,
    output logic [7:0] cap_o,
    output logic       cyc_busy_o,
    output logic       cyc_done_o,
    output logic       grant_o,
    output logic       deny_o
);
    localparam int CNT_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYC_LEN - 1);

    sr_state_e        state, nxt;
    logic [CNT_W-1:0] cnt;
    logic             allow, abort;

    assign allow = wel_i && !ext_busy_i && (wp_n_i || !arm_i);
    assign abort = (!wp_n_i && arm_i) || !wel_i;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_i && allow) nxt = ST_PEND;
            ST_PEND:  nxt = abort ? ST_IDLE : ST_CYCLE;
            ST_CYCLE: if (cnt == '0) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign commit_o   = (state == ST_PEND) && !abort;
    assign cyc_busy_o = (state == ST_CYCLE);
    assign cyc_done_o = (state == ST_CYCLE) && (cnt == '0);

    // State register, captured byte and cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cap_o <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && nxt == ST_PEND)
                cap_o <= data_i;
            if (commit_o)
                cnt <= CNT_LOAD;
            else if (state == ST_CYCLE && cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    // Registered handshake outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_o <= 1'b0;
            deny_o  <= 1'b0;
        end else begin
            grant_o <= commit_o;
            deny_o  <= (req_i && !(state == ST_IDLE && allow))
                     || (state == ST_PEND && abort);
        end
    end
endmodule

// File: rtl/statreg_guard.sv
module statreg_guard
    import swp_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int SR_CYC_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen_set_i,
    input  logic              wen_clr_i,
    input  logic              sr_wr_req_i,
    input  logic [7:0]        sr_wr_data_i,
    input  logic              chk_valid_i,
    input  logic [ADDR_W-1:0] chk_addr_i,
    input  logic              prog_busy_i,
    input  logic              wr_done_i,
    input  logic              wp_n_i,
    output logic [7:0]        status_o,
    output logic              sr_wr_grant_o,
    output logic              sr_wr_deny_o,
    output logic              arr_grant_o,
    output logic              arr_deny_o
);
    logic       arm_q;
    logic [1:0] lvl_q;
    logic       wel;
    logic       commit, cyc_busy, cyc_done;
    logic [7:0] cap;
    logic       busy_any, hit;

    assign busy_any = prog_busy_i || cyc_busy;

    swp_wel u_wel (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wen_set_i),
        .clr_i  (wen_clr_i || wr_done_i || cyc_done),
        .busy_i (busy_any),
        .wel_o  (wel)
    );

    swp_sr_fsm #(.CYC_LEN(SR_CYC_LEN)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (sr_wr_req_i),
        .data_i     (sr_wr_data_i),
        .wel_i      (wel),
        .arm_i      (arm_q),
        .wp_n_i     (wp_n_i),
        .ext_busy_i (busy_any),
        .commit_o   (commit),
        .cap_o      (cap),
        .cyc_busy_o (cyc_busy),
        .cyc_done_o (cyc_done),
        .grant_o    (sr_wr_grant_o),
        .deny_o     (sr_wr_deny_o)
    );

    swp_region #(.ADDR_W(ADDR_W)) u_region (
        .level_i (lvl_q),
        .addr_i  (chk_addr_i),
        .hit_o   (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
            lvl_q <= 2'b00;
        end else if (commit) begin
            arm_q <= cap[SB_ARM];
            lvl_q <= {cap[SB_LVL1], cap[SB_LVL0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_grant_o <= 1'b0;
            arr_deny_o  <= 1'b0;
        end else begin
            arr_grant_o <= chk_valid_i && wel && !busy_any && !hit;
            arr_deny_o  <= chk_valid_i && !(wel && !busy_any && !hit);
        end
    end

    always_comb begin
        status_o          = 8'h00;
        status_o[SB_ARM]  = arm_q;
        status_o[SB_LVL1] = lvl_q[1];
        status_o[SB_LVL0] = lvl_q[0];
        status_o[SB_WEL]  = wel || busy_any;
        status_o[SB_BUSY] = busy_any;
    end
endmodule

// File: rtl/statreg_guard_chk.sv
module statreg_guard_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n_i,
    input logic              wen_clr_i,
    input logic              wr_done_i,
    input logic              chk_valid_i,
    input logic [ADDR_W-1:0] chk_addr_i,
    input logic [7:0]        status_o,
    input logic              sr_wr_grant_o,
    input logic              sr_wr_deny_o,
    input logic              arr_grant_o,
    input logic              arr_deny_o
);
    AST_GRANT_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_grant_o |-> ($past(wp_n_i) || !$past(status_o[7]))); // R3

    AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_grant_o |-> $past(status_o[1])); // R3

    AST_SR_CHANGE_ONLY_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7:2] != $past(status_o[7:2])) |-> sr_wr_grant_o); // R4

    AST_SR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sr_wr_grant_o && sr_wr_deny_o)); // R6

    AST_WRDI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wen_clr_i) && !status_o[0]) |-> !status_o[1]); // R2

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_done_i) && !status_o[0]) |-> !status_o[1]); // R8

    AST_ARR_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chk_valid_i) |-> $onehot({arr_grant_o, arr_deny_o})); // R9

    AST_ARR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_grant_o |-> ($past(status_o[1]) && !$past(status_o[0]))); // R9

    AST_ARR_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        arr_grant_o |-> ($past(status_o[3:2]) != 2'b11)); // R10

    AST_ARR_HALF_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chk_valid_i) && $past(status_o[3:2]) == 2'b10
         && $past(chk_addr_i[ADDR_W-1])) |-> arr_deny_o); // R10
endmodule

bind statreg_guard statreg_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wp_n_i        (wp_n_i),
    .wen_clr_i     (wen_clr_i),
    .wr_done_i     (wr_done_i),
    .chk_valid_i   (chk_valid_i),
    .chk_addr_i    (chk_addr_i),
    .status_o      (status_o),
    .sr_wr_grant_o (sr_wr_grant_o),
    .sr_wr_deny_o  (sr_wr_deny_o),
    .arr_grant_o   (arr_grant_o),
    .arr_deny_o    (arr_deny_o)
);

// File: tb/statreg_guard_tb.sv
module statreg_guard_tb;
    localparam int AW  = 18;
    localparam int CYC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wen_set = 0, wen_clr = 0, sr_req = 0, chk_v = 0;
    logic [7:0]    sr_data = 0;
    logic [AW-1:0] chk_a = 0;
    logic          pbusy = 0, wdone = 0, wp_n = 1;
    logic [7:0]    status;
    logic          sg, sd, ag, ad;
    int            errors = 0, checks = 0;
    bit            done_flag = 0;

    always #4 clk = ~clk;

    statreg_guard #(.ADDR_W(AW), .SR_CYC_LEN(CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wen_set_i(wen_set), .wen_clr_i(wen_clr),
        .sr_wr_req_i(sr_req), .sr_wr_data_i(sr_data), .chk_valid_i(chk_v),
        .chk_addr_i(chk_a), .prog_busy_i(pbusy), .wr_done_i(wdone), .wp_n_i(wp_n),
        .status_o(status), .sr_wr_grant_o(sg), .sr_wr_deny_o(sd),
        .arr_grant_o(ag), .arr_deny_o(ad)
    );

    function automatic bit prot(input logic [1:0] lvl, input logic [AW-1:0] a);
        case (lvl)
            2'b00: return 1'b0;
            2'b01: return a >= AW'((3 << AW) / 4);
            2'b10: return a >= AW'((1 << AW) / 2);
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wren();
        wen_set = 1; tick(); wen_set = 0;
    endtask

    task automatic wrdi();
        wen_clr = 1; tick(); wen_clr = 0;
    endtask

    task automatic sr_write(input logic [7:0] d, output logic g, output logic dn);
        logic d1;
        sr_req = 1; sr_data = d; tick(); sr_req = 0;
        d1 = sd;
        tick();
        g = sg; dn = d1 | sd;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * CYC; i++) begin
            if (!status[0]) break;
            tick();
        end
    endtask

    task automatic set_lvl(input logic [7:0] d);
        logic g, dn;
        wren(); sr_write(d, g, dn); wait_idle();
    endtask

    task automatic query(input logic [AW-1:0] a, output logic g, output logic dn);
        chk_v = 1; chk_a = a; tick(); chk_v = 0;
        g = ag; dn = ad;
    endtask

    initial begin
        #(8 * 200000);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic g, dn, wel_exp;
        logic [1:0] lvl;
        logic [AW-1:0] a;
        int n;
        void'($urandom(32'h5A17));
        repeat (3) tick();
        check("R1 reset status", status, 8'h00);
        check("R1 reset handshakes", {sg, sd, ag, ad}, 4'b0000);
        rst_n = 1; tick();

        sr_write(8'h8C, g, dn);
        check("R3 no latch deny", {g, dn}, 2'b01);
        check("R3 status unchanged", status, 8'h00);

        wren();
        check("R2 set latch", status, 8'h02);
        wen_set = 1; wen_clr = 1; tick(); wen_set = 0; wen_clr = 0;
        check("R2 clear wins", status, 8'h00);
        wren(); wp_n = 0; wrdi(); wp_n = 1;
        check("R2 clear with pin low", status, 8'h00);

        wren();
        sr_write(8'hFC, g, dn);
        check("R4 grant", {g, dn}, 2'b10);
        check("R1 R7 layout while busy", status, 8'h8F);
        n = 0;
        while (status[0] && n < 4 * CYC) begin
            if (status[1] !== 1'b1) check("R7 wel reads 1", status[1], 1);
            n++; tick();
        end
        check("R7 busy length", n, CYC);
        check("R7 latch clear after", status, 8'h8C);

        wp_n = 0; wren();
        sr_write(8'h00, g, dn);
        check("R5 locked deny", {g, dn}, 2'b01);
        check("R5 arm bit kept", status, 8'h8E);
        wrdi(); wp_n = 1;

        set_lvl(8'h80);
        check("R4 level cleared arm kept", status, 8'h80);
        wren();
        sr_req = 1; sr_data = 8'h04; tick(); sr_req = 0; wp_n = 0;
        tick();
        check("R6 abort", {sg, sd}, 2'b01);
        check("R6 status and latch kept", status, 8'h82);
        wp_n = 1; wrdi();

        wren(); pbusy = 1; tick();
        check("R8 prog busy view", status & 8'h03, 8'h03);
        query(0, g, dn);
        check("R9 busy deny", {g, dn}, 2'b01);
        sr_write(8'h00, g, dn);
        check("R3 busy deny", {g, dn}, 2'b01);
        wdone = 1; pbusy = 0; tick(); wdone = 0;
        check("R8 done clears latch", status & 8'h03, 8'h00);
        pbusy = 1; wen_set = 1; tick(); wen_set = 0; pbusy = 0; tick();
        check("R2 set ignored while busy", status & 8'h03, 8'h00);

        set_lvl(8'h04);
        wren(); query(AW'(18'h2FFFF), g, dn);
        check("R10 quarter below", {g, dn}, 2'b10);
        query(AW'(18'h30000), g, dn);
        check("R10 quarter edge", {g, dn}, 2'b01);
        wrdi(); set_lvl(8'h08);
        wren(); query(AW'(18'h1FFFF), g, dn);
        check("R10 half below", {g, dn}, 2'b10);
        query(AW'(18'h20000), g, dn);
        check("R10 half edge", {g, dn}, 2'b01);
        wrdi();

        for (int it = 0; it < 150; it++) begin
            lvl = 2'($urandom % 4);
            set_lvl({1'b0, 3'($urandom), lvl, 2'($urandom)});
            check("R4 level written", status[3:2], lvl);
            wel_exp = 1'($urandom);
            if (wel_exp) wren();
            for (int k = 0; k < 4; k++) begin
                a = AW'($urandom);
                query(a, g, dn);
                check("R9 R10 random query", {g, dn},
                      (wel_exp && !prot(lvl, a)) ? 2'b10 : 2'b01);
            end
            wrdi();
        end

        done_flag = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule